// File: doc/BRIEF.md
# Compact 8-bit Register-ALU Execution Core

This block is a small execution core for 8-bit data. It fetches 16-bit instruction words from a program ROM port through an instruction register. It runs a four-instruction subset on a file of thirty-two 8-bit registers:

- load a constant,
- add two registers,
- copy a register,
- unsigned multiply.

Arithmetic uses a two-operand form, so the register named as destination is also the first source. A move is a plain pass of the second operand through the ALU.

A separate combinational multiplier array sits beside the ALU. It reads the same two source buses and takes two execute slots. Its 16-bit product always lands in the fixed pair R1:R0, whatever source registers the instruction names.

A debug port reads any register without disturbing execution. The carry and zero flags are brought out for observation.

Top module: `mini8_core`

## Requirements
- R1: While reset is asserted and right after its release, the instruction address is 0, every register reads 0 on the debug port, and both flags are 0.
- R2: A word with bits 15:12 equal to 1110 loads a constant into register 16+d. The 4-bit d is taken from bits 7:4. The constant's upper nibble comes from bits 11:8 and its lower nibble from bits 3:0.
- R3: A word with bits 15:10 equal to 000011 adds, so Rd becomes (Rd + Rr) mod 256. Here d = {bit 8, bits 7:4} and r = {bit 9, bits 3:0}, which reaches all 32 registers.
- R4: An add sets carry to bit 8 of the 9-bit sum and sets zero when the 8-bit result is 0. No other instruction changes either flag.
- R5: A word with bits 15:10 equal to 001011 copies Rr into Rd, using the same field layout as add. Rr is left unchanged.
- R6: A word with bits 15:10 equal to 100111 multiplies the two named registers, using the same field layout as add. The unsigned 16-bit product is written with its high byte in R1 and its low byte in R0, even when R0 or R1 are the sources.
- R7: The instruction at word k is the (k+1)-th word fetched, and its result is visible after rising edge k+2 past reset release when no multiply comes earlier. The address advances by exactly one word per issued instruction.
- R8: A multiply occupies two execute cycles. In its first cycle the address holds and R1:R0 keep their old value. The product appears after the second cycle. Each earlier multiply delays later instructions by one edge.
- R9: Any word not matching the four patterns changes no register and no flag.
- R10: The debug port combinationally returns the register selected by dbg_sel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | PC_W | Word address of the next instruction to fetch |
| imem_data | input | 16 | Instruction word at imem_addr, same cycle |
| dbg_sel | input | 5 | Register index for the debug read |
| dbg_data | output | 8 | Contents of the selected register |
| flag_c | output | 1 | Carry from the last add |
| flag_z | output | 1 | Zero result of the last add |

## Verification
The directed tests cover the following corner cases:

- **Split operand fields.** A decoder that dropped bit 8 or bit 9 would write to, or read from, a register 16 lower.
- **Full-scale add.** 0xFF + 0x01 must set carry and zero together. A later move or an undecoded word must leave both flags as they were. A design that cleared flags on other instructions would show wrong flags there.
- **Multiply timing.** The bench samples the middle cycle of a multiply, where the address must hold and R0 must still be old. A one-cycle or non-stalling multiplier would show the product early or skip an address.
- **Multiply on its own destinations.** A multiply whose sources are R0 and R1 themselves must use the old values. A design that forwarded half-written results would give a wrong product.

// File: rtl/mini8_pkg.sv
package mini8_pkg;

   localparam int INSN_W = 16;
   localparam int DATA_W = 8;
   localparam int RIDX_W = 5;

   localparam logic [3:0] OPC_LDI = 4'b1110;
   localparam logic [5:0] OPC_ADD = 6'b000011;
   localparam logic [5:0] OPC_MOV = 6'b001011;
   localparam logic [5:0] OPC_MUL = 6'b100111;

   typedef enum logic [2:0] {
      OP_NOP,
      OP_LDI,
      OP_ADD,
      OP_MOV,
      OP_MUL
   } op_e;

   typedef struct packed {
      op_e               op;
      logic [RIDX_W-1:0] rd;
      logic [RIDX_W-1:0] rr;
      logic [DATA_W-1:0] imm;
   } dec_t;

endpackage

// File: rtl/mini8_decode.sv
module mini8_decode
   import mini8_pkg::*;
(
   input  logic [INSN_W-1:0] insn,
   input  logic              valid,
   output dec_t              dec
);

   always_comb begin
      dec.rd  = {insn[8], insn[7:4]};
      dec.rr  = {insn[9], insn[3:0]};
      dec.imm = {insn[11:8], insn[3:0]};
      dec.op  = OP_NOP;
      if (valid) begin
         if (insn[15:12] == OPC_LDI) begin
            dec.op = OP_LDI;
            dec.rd = {1'b1, insn[7:4]};
         end else if (insn[15:10] == OPC_ADD) begin
            dec.op = OP_ADD;
         end else if (insn[15:10] == OPC_MOV) begin
            dec.op = OP_MOV;
         end else if (insn[15:10] == OPC_MUL) begin
            dec.op = OP_MUL;
         end
      end
   end

endmodule

// File: rtl/mini8_regfile.sv
module mini8_regfile #(
   parameter  int DATA_W = 8,
   parameter  int NREGS  = 32,
   localparam int IDX_W  = $clog2(NREGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IDX_W-1:0]    ra_idx,
   input  logic [IDX_W-1:0]    rb_idx,
   output logic [DATA_W-1:0]   ra_data,
   output logic [DATA_W-1:0]   rb_data,
   input  logic                we_a,
   input  logic [IDX_W-1:0]    wa_idx,
   input  logic [DATA_W-1:0]   wa_data,
   input  logic                we_pair,
   input  logic [2*DATA_W-1:0] pair_data,
   input  logic [IDX_W-1:0]    dbg_idx,
   output logic [DATA_W-1:0]   dbg_data
);

   logic [DATA_W-1:0] mem_q [NREGS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREGS; i++) mem_q[i] <= '0;
      end else begin
         if (we_a) mem_q[wa_idx] <= wa_data;
         if (we_pair) begin
            mem_q[0] <= pair_data[DATA_W-1:0];
            mem_q[1] <= pair_data[2*DATA_W-1:DATA_W];
         end
      end
   end

   assign ra_data  = mem_q[ra_idx];
   assign rb_data  = mem_q[rb_idx];
   assign dbg_data = mem_q[dbg_idx];

endmodule

// File: rtl/mini8_alu.sv
module mini8_alu #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              do_add,
   output logic [DATA_W-1:0] y,
   output logic              cout,
   output logic              zero
);

   logic [DATA_W:0] sum;

   assign sum  = {1'b0, a} + {1'b0, b};
   assign y    = do_add ? sum[DATA_W-1:0] : b;
   assign cout = sum[DATA_W];
   assign zero = (sum[DATA_W-1:0] == '0);

endmodule

// File: rtl/mini8_mul.sv
module mini8_mul #(
   parameter int DATA_W = 8,
   parameter bit ARRAY  = 1'b1
) (
   input  logic [DATA_W-1:0]   a,
   input  logic [DATA_W-1:0]   b,
   output logic [2*DATA_W-1:0] y
);

   localparam int PW = 2 * DATA_W;

   generate
      if (ARRAY) begin : g_array
         logic [PW-1:0] acc [DATA_W+1];
         assign acc[0] = '0;
         for (genvar i = 0; i < DATA_W; i++) begin : g_row
            logic [PW-1:0] pp;
            assign pp         = {{DATA_W{1'b0}}, a & {DATA_W{b[i]}}} << i;
            assign acc[i + 1] = acc[i] + pp;
         end
         assign y = acc[DATA_W];
      end else begin : g_op
         assign y = PW'(a) * PW'(b);
      end
   endgenerate

endmodule

// File: rtl/mini8_core.sv
module mini8_core
   import mini8_pkg::*;
#(
   parameter  int PC_W      = 16,
   parameter  int NREGS     = 32,
   parameter  bit MUL_ARRAY = 1'b1,
   localparam int SEL_W     = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [PC_W-1:0]   imem_addr,
   input  logic [INSN_W-1:0] imem_data,
   input  logic [SEL_W-1:0]  dbg_sel,
   output logic [DATA_W-1:0] dbg_data,
   output logic              flag_c,
   output logic              flag_z
);

   generate
      if (NREGS != 32) begin : g_bad_nregs
         $error("mini8_core: operand fields address exactly 32 registers");
      end
      if (PC_W < 2) begin : g_bad_pcw
         $error("mini8_core: PC_W must be at least 2");
      end
   endgenerate

   logic [PC_W-1:0]     pc_q;
   logic [INSN_W-1:0]   ir_q;
   logic                irv_q;
   logic                mbusy_q;
   logic [2*DATA_W-1:0] prod_q;
   logic                fc_q, fz_q;

   dec_t                dec;
   logic [DATA_W-1:0]   opa, opb, alu_y;
   logic                alu_c, alu_z;
   logic [2*DATA_W-1:0] mul_y;
   logic                mul_issue, rf_we;
   logic [DATA_W-1:0]   rf_wdata;

   mini8_decode u_dec (
      .insn  (ir_q),
      .valid (irv_q),
      .dec   (dec)
   );

   mini8_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
      .clk       (clk),
      .rst_n     (rst_n),
      .ra_idx    (dec.rd),
      .rb_idx    (dec.rr),
      .ra_data   (opa),
      .rb_data   (opb),
      .we_a      (rf_we),
      .wa_idx    (dec.rd),
      .wa_data   (rf_wdata),
      .we_pair   (mbusy_q),
      .pair_data (prod_q),
      .dbg_idx   (dbg_sel),
      .dbg_data  (dbg_data)
   );

   mini8_alu #(.DATA_W(DATA_W)) u_alu (
      .a      (opa),
      .b      (opb),
      .do_add (dec.op == OP_ADD),
      .y      (alu_y),
      .cout   (alu_c),
      .zero   (alu_z)
   );

   mini8_mul #(.DATA_W(DATA_W), .ARRAY(MUL_ARRAY)) u_mul (
      .a (opa),
      .b (opb),
      .y (mul_y)
   );

   assign mul_issue = (dec.op == OP_MUL) && !mbusy_q;
   assign rf_we     = (dec.op == OP_LDI) || (dec.op == OP_ADD) || (dec.op == OP_MOV);
   assign rf_wdata  = (dec.op == OP_LDI) ? dec.imm : alu_y;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q    <= '0;
         ir_q    <= '0;
         irv_q   <= 1'b0;
         mbusy_q <= 1'b0;
         prod_q  <= '0;
         fc_q    <= 1'b0;
         fz_q    <= 1'b0;
      end else begin
         mbusy_q <= mul_issue;
         if (mul_issue) prod_q <= mul_y;
         if (!mul_issue) begin
            pc_q  <= pc_q + 1'b1;
            ir_q  <= imem_data;
            irv_q <= 1'b1;
         end
         if (dec.op == OP_ADD) begin
            fc_q <= alu_c;
            fz_q <= alu_z;
         end
      end
   end

   assign imem_addr = pc_q;
   assign flag_c    = fc_q;
   assign flag_z    = fz_q;

endmodule

// File: rtl/mini8_core_chk.sv
module mini8_core_chk
   import mini8_pkg::*;
#(
   parameter int PC_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [PC_W-1:0]   imem_addr,
   input logic              flag_c,
   input logic              flag_z,
   input logic              issue,
   input logic              mbusy,
   input logic              is_add,
   input logic [DATA_W-1:0] opa,
   input logic [DATA_W-1:0] opb,
   input logic [DATA_W-1:0] r0,
   input logic [DATA_W-1:0] r1
);

   assert_pc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (imem_addr != $past(imem_addr)) |-> (imem_addr == PC_W'($past(imem_addr) + 1'b1)));

   assert_mul_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> $stable(imem_addr));

   assert_mul_two_R8: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> (mbusy && !issue));

   assert_mul_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> ##1 ({r1, r0} == (16'($past(opa, 2)) * 16'($past(opb, 2)))));

   assert_flags_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !is_add |=> ($stable(flag_c) && $stable(flag_z)));

endmodule

bind mini8_core mini8_core_chk #(.PC_W(PC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .imem_addr (imem_addr),
   .flag_c    (flag_c),
   .flag_z    (flag_z),
   .issue     (mul_issue),
   .mbusy     (mbusy_q),
   .is_add    (dec.op == mini8_pkg::OP_ADD),
   .opa       (opa),
   .opb       (opb),
   .r0        (u_rf.mem_q[0]),
   .r1        (u_rf.mem_q[1])
);

// File: tb/tb_mini8_core.sv
`timescale 1ns/1ps
module tb_mini8_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] imem_addr;
   logic [15:0] imem_data;
   logic [4:0]  dbg_sel = '0;
   logic [7:0]  dbg_data;
   logic        flag_c, flag_z;
   logic [15:0] rom [64];

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;

   always #4 clk = ~clk;

   assign imem_data = rom[imem_addr[5:0]];

   mini8_core dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .imem_addr (imem_addr),
      .imem_data (imem_data),
      .dbg_sel   (dbg_sel),
      .dbg_data  (dbg_data),
      .flag_c    (flag_c),
      .flag_z    (flag_z)
   );

   function automatic logic [15:0] f_ldi(int d, int k);
      return {4'b1110, 4'(k >> 4), 4'(d - 16), 4'(k)};
   endfunction
   function automatic logic [15:0] f_rr(logic [5:0] opc, int d, int r);
      logic [4:0] dd = 5'(d);
      logic [4:0] rr = 5'(r);
      return {opc, rr[4], dd[4], dd[3:0], rr[3:0]};
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic chk_reg(string tag, int idx, logic [7:0] exp);
      dbg_sel = 5'(idx);
      #1;
      chk(tag, 32'(dbg_data), 32'(exp));
   endtask

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic start(input logic [15:0] prog [8]);
      for (int i = 0; i < 64; i++) rom[i] = 16'h0000;
      for (int i = 0; i < 8; i++) rom[i] = prog[i];
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
   endtask

   // R1, R10: reset state, all registers via debug port
   task automatic t_reset();
      logic [15:0] p [8];
      for (int i = 0; i < 8; i++) p[i] = 16'h0000;
      start(p);
      chk("R1 addr after reset", 32'(imem_addr), 0);
      chk("R1 carry after reset", 32'(flag_c), 0);
      chk("R1 zero after reset", 32'(flag_z), 0);
      for (int i = 0; i < 32; i++) chk_reg("R1 R10 register clear", i, 8'h00);
   endtask

   // R2, R3, R6, R7, R8: two loads, add, multiply
   task automatic t_main();
      logic [15:0] p [8];
      for (int i = 0; i < 8; i++) p[i] = 16'h0000;
      p[0] = f_ldi(16, 10);
      p[1] = f_ldi(17, 20);
      p[2] = f_rr(6'b000011, 16, 17);
      p[3] = f_rr(6'b100111, 16, 17);
      start(p);
      step(2);
      chk_reg("R2 R7 r16 after edge 2", 16, 8'd10);
      chk_reg("R7 r17 not yet loaded", 17, 8'd0);
      step(1);
      chk_reg("R2 r17 load", 17, 8'd20);
      step(1);
      chk_reg("R3 r16 = 10+20", 16, 8'd30);
      chk("R4 carry clear", 32'(flag_c), 0);
      chk("R4 zero clear", 32'(flag_z), 0);
      step(1);
      chk("R8 addr held in mul slot", 32'(imem_addr), 4);
      chk_reg("R8 r0 still old", 0, 8'h00);
      step(1);
      chk_reg("R6 R8 r0 product low", 0, 8'h58);
      chk_reg("R6 R8 r1 product high", 1, 8'h02);
      chk("R7 addr after mul", 32'(imem_addr), 5);
      chk_reg("R6 r16 untouched", 16, 8'd30);
      chk_reg("R6 r17 untouched", 17, 8'd20);
   endtask

   // R3, R4, R5, R9: carry and zero, upper field bits, move, undecoded word
   task automatic t_flags();
      logic [15:0] p [8];
      for (int i = 0; i < 8; i++) p[i] = 16'h0000;
      p[0] = f_ldi(20, 8'hFF);
      p[1] = f_ldi(21, 8'h01);
      p[2] = f_rr(6'b000011, 20, 21);
      p[3] = f_rr(6'b001011, 9, 21);
      p[4] = 16'hFFFF;
      p[5] = f_rr(6'b000011, 9, 9);
      start(p);
      step(4);
      chk_reg("R3 r20 wraps to 0", 20, 8'h00);
      chk_reg("R3 r4 not written by lost bit 8", 4, 8'h00);
      chk("R4 carry set", 32'(flag_c), 1);
      chk("R4 zero set", 32'(flag_z), 1);
      step(1);
      chk_reg("R5 r9 copy", 9, 8'h01);
      chk_reg("R5 r21 source kept", 21, 8'h01);
      chk("R4 R5 carry kept after move", 32'(flag_c), 1);
      chk("R4 R5 zero kept after move", 32'(flag_z), 1);
      step(1);
      chk_reg("R9 r9 after undecoded", 9, 8'h01);
      chk_reg("R9 r31 after undecoded", 31, 8'h00);
      chk_reg("R9 r20 after undecoded", 20, 8'h00);
      chk("R9 carry after undecoded", 32'(flag_c), 1);
      chk("R9 zero after undecoded", 32'(flag_z), 1);
      chk("R7 addr after six edges", 32'(imem_addr), 6);
      step(1);
      chk_reg("R3 r9 doubled", 9, 8'h02);
      chk("R4 carry cleared by add", 32'(flag_c), 0);
      chk("R4 zero cleared by add", 32'(flag_z), 0);
   endtask

   // R6, R8: full-scale multiply, then multiply reading R0/R1 themselves
   task automatic t_mulpair();
      logic [15:0] p [8];
      for (int i = 0; i < 8; i++) p[i] = 16'h0000;
      p[0] = f_ldi(30, 8'hFF);
      p[1] = f_ldi(31, 8'hFF);
      p[2] = f_rr(6'b100111, 30, 31);
      p[3] = f_rr(6'b100111, 0, 1);
      p[4] = f_ldi(18, 8'h5A);
      start(p);
      step(4);
      chk("R8 addr held first mul", 32'(imem_addr), 3);
      step(1);
      chk_reg("R6 r0 of FF*FF", 0, 8'h01);
      chk_reg("R6 r1 of FF*FF", 1, 8'hFE);
      chk_reg("R2 r31 reachable", 31, 8'hFF);
      step(1);
      chk("R8 addr held second mul", 32'(imem_addr), 4);
      chk_reg("R8 r0 old during second mul", 0, 8'h01);
      step(1);
      chk_reg("R6 r0 of 01*FE", 0, 8'hFE);
      chk_reg("R6 r1 of 01*FE", 1, 8'h00);
      chk("R7 R8 addr after two muls", 32'(imem_addr), 5);
      step(1);
      chk_reg("R8 load after two muls", 18, 8'h5A);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got %0d cycles expected fewer than 20000", cycles);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_main();
      t_flags();
      t_mulpair();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule